// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits between the error-correction chain and a downstream demultiplexer. It receives decoded transport bytes one at a time, framed by a marker on the first byte of each packet and a flag that says whether the error decoder could not correct the packet. It trims each packet to its payload length, which is 188 bytes for DVB or 130 bytes for DSS. It marks uncorrectable DVB packets in their header. It then sends the bytes out either as a byte-wide bus or as a single serial line.

Each output unit is one byte in parallel mode or one bit in serial mode. A unit lasts two system clocks. The output clock is low in the first of these clocks and high in the second, so its rising edge falls in the middle of stable data. Static control inputs set the output mode, the packet length, the clock polarity, the meaning and polarity of the error pin, and the pad drive enable. Change them only while the output is idle.

Top module: `ts_out_fmt`

## Requirements
- R1: In parallel mode, every kept byte is presented on `ts_data_o` for one output clock period of two system clocks. `ts_valid_o` is high throughout, and the data is stable across the rising edge of the non-inverted output clock.
- R2: `ts_start_o` is high for exactly the output period of the first byte of each packet (the byte that came with `in_start_i`). It is low at all other times and never high without `ts_valid_o`.
- R3: In serial mode, each byte is sent on `ts_data_o[0]`, most significant bit first, over 8 output clocks. `ts_data_o[7:1]` is 0. `ts_start_o` stays high over all 8 bits of a packet's first byte.
- R4: With `cfg_dss_i`=0 a packet keeps its first 188 bytes; with `cfg_dss_i`=1 it keeps its first 130. Bytes after that count and before the next start marker are dropped, and so are bytes that arrive before the first start marker after reset.
- R5: With `cfg_dss_i`=0, if a packet arrived with `in_uncorr_i`=1 on its start byte, bit 7 of its second byte (byte index 1) is forced to 1. That bit is never cleared, and all other bytes pass unchanged.
- R6: With `cfg_dss_i`=1, no byte of any packet is modified.
- R7: With `cfg_err_nosig_i`=0 and `cfg_err_inv_i`=0, `ts_err_o` is 0 while bytes of an uncorrectable packet are output and 1 otherwise, including when idle.
- R8: With `cfg_err_nosig_i`=1 and `cfg_err_inv_i`=0, `ts_err_o` is the inverse of `sig_lost_i` as sampled at the previous clock edge.
- R9: `cfg_err_inv_i`=1 inverts `ts_err_o` in both error-pin modes.
- R10: `ts_clk_o` is the internal output clock XOR `cfg_clk_inv_i`. The clock stays low (or high when inverted) while idle.
- R11: Out of reset and whenever no data is pending, `ts_valid_o` and `ts_start_o` are 0 and `ts_data_o` keeps the last value it carried (0 after reset).
- R12: `ts_oe_o` follows `cfg_oe_i` combinationally. It is the pad drive enable for data, clock and strobes; a low level places them in high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid for one cycle |
| in_data_i | input | 8 | Input byte |
| in_start_i | input | 1 | Input byte is first of a packet |
| in_uncorr_i | input | 1 | Packet uncorrectable (read with the start byte) |
| sig_lost_i | input | 1 | No-signal condition from the demodulator |
| cfg_serial_i | input | 1 | 1 = serial output, 0 = parallel |
| cfg_dss_i | input | 1 | 1 = 130-byte packets, 0 = 188-byte packets with header marking |
| cfg_clk_inv_i | input | 1 | Invert output clock |
| cfg_err_nosig_i | input | 1 | Error pin mode: 1 = no signal, 0 = bad block |
| cfg_err_inv_i | input | 1 | Invert error pin |
| cfg_oe_i | input | 1 | Output drive enable |
| ts_clk_o | output | 1 | Byte or bit clock |
| ts_data_o | output | 8 | Parallel data, or serial bit on bit 0 |
| ts_start_o | output | 1 | First-byte strobe |
| ts_valid_o | output | 1 | Data valid strobe |
| ts_err_o | output | 1 | Error indicator, active low |
| ts_oe_o | output | 1 | Pad drive enable |

## Verification
A wrong byte-index counter shows up within one packet. The 189th byte leaks out, the start strobe lands on the wrong byte, or the header mark hits the wrong byte, and the scoreboard sees any of these at the next output clock edge. A stuck phase or bit counter in the output stage breaks the serial reassembly of the very next byte, or drops the clock edge while valid is high. A wrong error-flag latch shows on the error pin during the first byte of the affected packet. A stale no-signal register appears one cycle after `sig_lost_i` changes.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned DVB_PKT_LEN = 188;
  localparam int unsigned DSS_PKT_LEN = 130;
  localparam int unsigned MARK_IDX    = 1;          // header byte carrying the error mark
  localparam int unsigned MARK_BIT    = BYTE_W - 1; // its most significant bit

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              first;
    logic              bad;
  } ts_item_t;

  localparam int unsigned ITEM_W = $bits(ts_item_t);
endpackage

// File: rtl/ts_item_fifo.sv
module ts_item_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic         empty_o,
  output logic [W-1:0] head_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]   mem_q [DEPTH];
  logic [PTR_W:0] wp_q, rp_q;
  logic           full;

  assign empty_o = (wp_q == rp_q);
  assign full    = (wp_q[PTR_W] != rp_q[PTR_W]) &&
                   (wp_q[PTR_W-1:0] == rp_q[PTR_W-1:0]);
  assign head_o  = mem_q[rp_q[PTR_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i && !full) wp_q <= wp_q + 1'b1;
      if (pop_i && !empty_o) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem_q[wp_q[PTR_W-1:0]] <= push_data_i;
  end
endmodule

// File: rtl/ts_pkt_track.sv
module ts_pkt_track
  import ts_out_pkg::*;
#(
  parameter int unsigned DVB_LEN = DVB_PKT_LEN,
  parameter int unsigned DSS_LEN = DSS_PKT_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_start_i,
  input  logic              in_uncorr_i,
  input  logic              cfg_dss_i,
  output logic              push_o,
  output ts_item_t          item_o
);
  localparam int unsigned IDX_W = $clog2(DVB_LEN + 2);

  logic [IDX_W-1:0] idx_q, idx_cur, pkt_len;
  logic             bad_q, bad_cur;

  assign pkt_len = cfg_dss_i ? IDX_W'(DSS_LEN) : IDX_W'(DVB_LEN);
  assign idx_cur = in_start_i ? '0 : idx_q;
  assign bad_cur = in_start_i ? in_uncorr_i : bad_q;
  assign push_o  = in_valid_i && (idx_cur < pkt_len);

  always_comb begin
    item_o.data  = in_data_i;
    item_o.first = (idx_cur == '0);
    item_o.bad   = bad_cur;
    if (!cfg_dss_i && bad_cur && (idx_cur == IDX_W'(MARK_IDX)))
      item_o.data[MARK_BIT] = 1'b1;
  end

  // idx saturates at all-ones: "outside any packet"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '1;
      bad_q <= 1'b0;
    end else if (in_valid_i) begin
      idx_q <= (idx_cur == '1) ? idx_cur : idx_cur + 1'b1;
      bad_q <= bad_cur;
    end
  end
endmodule

// File: rtl/ts_out_shift.sv
module ts_out_shift
  import ts_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_serial_i,
  input  logic              empty_i,
  input  ts_item_t          item_i,
  output logic              pop_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              first_o,
  output logic              valid_o,
  output logic              bad_o,
  output logic              clk_o
);
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic              busy_q, ph_q, clk_q, valid_q, first_q, bad_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-2:0] sh_q;
  logic [BYTE_W-1:0] data_q;
  logic              unit_end, more_bits, load;

  // a unit ends on its high phase; serial needs all bits done
  assign unit_end  = busy_q && ph_q && (!cfg_serial_i || (bit_q == LAST_BIT));
  assign more_bits = busy_q && ph_q && cfg_serial_i && (bit_q != LAST_BIT);
  assign load      = (!busy_q || unit_end) && !empty_i;
  assign pop_o     = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ph_q    <= 1'b0;
      clk_q   <= 1'b0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
      bad_q   <= 1'b0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      ph_q    <= 1'b0;
      clk_q   <= 1'b0;
      valid_q <= 1'b1;
      first_q <= item_i.first;
      bad_q   <= item_i.bad;
      bit_q   <= '0;
      sh_q    <= item_i.data[BYTE_W-2:0];
      data_q  <= cfg_serial_i ? {{(BYTE_W-1){1'b0}}, item_i.data[BYTE_W-1]}
                              : item_i.data;
    end else if (busy_q && !ph_q) begin
      ph_q  <= 1'b1;
      clk_q <= 1'b1;
    end else if (more_bits) begin
      ph_q   <= 1'b0;
      clk_q  <= 1'b0;
      bit_q  <= bit_q + 1'b1;
      data_q <= {{(BYTE_W-1){1'b0}}, sh_q[BYTE_W-2]};
      sh_q   <= {sh_q[BYTE_W-3:0], 1'b0};
    end else if (unit_end) begin
      busy_q  <= 1'b0;
      ph_q    <= 1'b0;
      clk_q   <= 1'b0;
      valid_q <= 1'b0;
      first_q <= 1'b0;
      bad_q   <= 1'b0;
    end
  end

  assign data_o  = data_q;
  assign first_o = first_q;
  assign valid_o = valid_q;
  assign bad_o   = bad_q;
  assign clk_o   = clk_q;
endmodule

// File: rtl/ts_err_pin.sv
module ts_err_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_lost_i,
  input  logic cfg_nosig_i,
  input  logic cfg_inv_i,
  input  logic valid_i,
  input  logic bad_i,
  output logic err_o
);
  logic sig_q, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_lost_i;
  end

  assign active = cfg_nosig_i ? sig_q : (valid_i && bad_i);
  assign err_o  = !active ^ cfg_inv_i;
endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
  import ts_out_pkg::*;
#(
  parameter int unsigned DVB_LEN    = DVB_PKT_LEN,
  parameter int unsigned DSS_LEN    = DSS_PKT_LEN,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_start_i,
  input  logic       in_uncorr_i,
  input  logic       sig_lost_i,
  input  logic       cfg_serial_i,
  input  logic       cfg_dss_i,
  input  logic       cfg_clk_inv_i,
  input  logic       cfg_err_nosig_i,
  input  logic       cfg_err_inv_i,
  input  logic       cfg_oe_i,
  output logic       ts_clk_o,
  output logic [7:0] ts_data_o,
  output logic       ts_start_o,
  output logic       ts_valid_o,
  output logic       ts_err_o,
  output logic       ts_oe_o
);
  logic        push, pop, empty, bad, clk_raw;
  ts_item_t    in_item, head_item;
  logic [ITEM_W-1:0] head_bits;

  ts_pkt_track #(.DVB_LEN(DVB_LEN), .DSS_LEN(DSS_LEN)) u_track (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i, .in_start_i, .in_uncorr_i,
    .cfg_dss_i, .push_o(push), .item_o(in_item)
  );

  ts_item_fifo #(.W(ITEM_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .push_data_i(in_item),
    .pop_i(pop), .empty_o(empty), .head_o(head_bits)
  );

  assign head_item = ts_item_t'(head_bits);

  ts_out_shift u_shift (
    .clk_i, .rst_ni, .cfg_serial_i, .empty_i(empty), .item_i(head_item),
    .pop_o(pop), .data_o(ts_data_o), .first_o(ts_start_o),
    .valid_o(ts_valid_o), .bad_o(bad), .clk_o(clk_raw)
  );

  ts_err_pin u_err (
    .clk_i, .rst_ni, .sig_lost_i, .cfg_nosig_i(cfg_err_nosig_i),
    .cfg_inv_i(cfg_err_inv_i), .valid_i(ts_valid_o), .bad_i(bad),
    .err_o(ts_err_o)
  );

  assign ts_clk_o = clk_raw ^ cfg_clk_inv_i;
  assign ts_oe_o  = cfg_oe_i;
endmodule

// File: rtl/ts_out_fmt_chk.sv
module ts_out_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sig_lost_i,
  input logic       cfg_serial_i,
  input logic       cfg_clk_inv_i,
  input logic       cfg_err_nosig_i,
  input logic       cfg_err_inv_i,
  input logic       ts_clk_o,
  input logic [7:0] ts_data_o,
  input logic       ts_start_o,
  input logic       ts_valid_o,
  input logic       ts_err_o
);
  // R2
  start_in_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_start_o |-> ts_valid_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_valid_o |=> (ts_valid_o || $stable(ts_data_o)));

  // R1
  edge_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ts_clk_o ^ cfg_clk_inv_i) |-> ($stable(ts_data_o) && ts_valid_o));

  // R3
  serial_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_serial_i && ts_valid_o) |-> (ts_data_o[7:1] == 7'd0));

  // R7
  idle_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_err_nosig_i && !ts_valid_o) |-> (ts_err_o == !cfg_err_inv_i));

  // R8
  nosig_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_nosig_i && $past(cfg_err_nosig_i) && $past(rst_ni))
      |-> (ts_err_o == (!$past(sig_lost_i) ^ cfg_err_inv_i)));
endmodule

bind ts_out_fmt ts_out_fmt_chk chk_i (.*);

// File: tb/ts_out_fmt_tb_top.sv
module ts_out_fmt_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       in_valid = 0, in_start = 0, in_uncorr = 0, sig_lost = 0;
  logic [7:0] in_data = '0;
  logic       cfg_serial = 0, cfg_dss = 0, cfg_clk_inv = 0;
  logic       cfg_err_nosig = 0, cfg_err_inv = 0, cfg_oe = 1;
  logic       ts_clk_o, ts_start_o, ts_valid_o, ts_err_o, ts_oe_o;
  logic [7:0] ts_data_o;

  ts_out_fmt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_start_i(in_start), .in_uncorr_i(in_uncorr), .sig_lost_i(sig_lost),
    .cfg_serial_i(cfg_serial), .cfg_dss_i(cfg_dss), .cfg_clk_inv_i(cfg_clk_inv),
    .cfg_err_nosig_i(cfg_err_nosig), .cfg_err_inv_i(cfg_err_inv), .cfg_oe_i(cfg_oe),
    .ts_clk_o, .ts_data_o, .ts_start_o, .ts_valid_o, .ts_err_o, .ts_oe_o
  );

  typedef struct { logic [7:0] d; logic first; logic bad; } exp_t;
  exp_t       sb[$];
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;
  logic [7:0] last_byte = '0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: sample away from the active edge, act on output clock rising
  logic       prev_raw = 0, st0 = 0, raw;
  bit         st_bad = 0;
  logic [7:0] acc = '0;
  int         nb = 0;
  exp_t       e;
  always @(negedge clk) begin
    raw = ts_clk_o ^ cfg_clk_inv;
    if (rst_n && raw && !prev_raw) begin
      if (!ts_valid_o) chk(0, "R1", "valid at clock edge", 0, 1);
      else if (!cfg_serial) begin
        if (sb.size() == 0) chk(0, "R4", "unexpected byte", ts_data_o, 0);
        else begin
          e = sb.pop_front();
          chk(ts_data_o == e.d, "R1", "parallel data", ts_data_o, e.d);
          chk(ts_start_o == e.first, "R2", "start strobe", ts_start_o, e.first);
          chk(ts_err_o == (!e.bad ^ cfg_err_inv), "R7", "block error pin",
              ts_err_o, !e.bad ^ cfg_err_inv);
        end
      end else begin
        if (nb == 0) begin st0 = ts_start_o; st_bad = 0; end
        else if (ts_start_o != st0) st_bad = 1;
        acc = {acc[6:0], ts_data_o[0]};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (sb.size() == 0) chk(0, "R4", "unexpected serial byte", acc, 0);
          else begin
            e = sb.pop_front();
            chk(acc == e.d, "R3", "serial byte", acc, e.d);
            chk(st0 == e.first && !st_bad, "R3", "serial start span", st0, e.first);
            chk(ts_err_o == (!e.bad ^ cfg_err_inv), "R7", "serial error pin",
                ts_err_o, !e.bad ^ cfg_err_inv);
          end
        end
      end
    end
    prev_raw = raw;
  end

  task automatic put_byte(logic [7:0] d, bit st, bit unc, int gap);
    @(negedge clk);
    in_valid = 1; in_data = d; in_start = st; in_uncorr = unc;
    @(negedge clk);
    in_valid = 0; in_start = 0; in_uncorr = 0;
    repeat (gap - 2) @(negedge clk);
  endtask

  // driver: pushes expected items (R4 trim, R5/R6 header marking)
  task automatic send_pkt(int nsent, bit unc, int seed, logic [7:0] b1, int gap);
    int len = cfg_dss ? 130 : 188;
    for (int i = 0; i < nsent; i++) begin
      logic [7:0] d;
      exp_t x;
      d = (i == 0) ? 8'h47 : (i == 1) ? b1 : 8'(seed + i * 7);
      if (i < len) begin
        x.d = d;
        if (!cfg_dss && unc && i == 1) x.d[7] = 1'b1;
        x.first = (i == 0);
        x.bad = unc;
        sb.push_back(x);
        last_byte = x.d;
      end
      put_byte(d, i == 0, unc, gap);
    end
  endtask

  task automatic drain_and_idle(string tag);
    while (sb.size() != 0 || ts_valid_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(ts_valid_o == 0 && ts_start_o == 0, "R11", tag, ts_valid_o, 0);
    if (cfg_serial)
      chk(ts_data_o == {7'd0, last_byte[0]}, "R11", "serial hold", ts_data_o, last_byte[0]);
    else
      chk(ts_data_o == last_byte, "R11", "parallel hold", ts_data_o, last_byte);
    chk(ts_clk_o == cfg_clk_inv, "R10", "idle clock level", ts_clk_o, cfg_clk_inv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ts_valid_o == 0, "R11", "reset valid", ts_valid_o, 0);
    chk(ts_start_o == 0, "R2", "reset start", ts_start_o, 0);
    chk(ts_data_o == 0, "R11", "reset data", ts_data_o, 0);
    chk(ts_err_o == 1, "R7", "reset error pin", ts_err_o, 1);
    chk(ts_clk_o == 0, "R10", "reset clock", ts_clk_o, 0);
    chk(ts_oe_o == 1, "R12", "oe high", ts_oe_o, 1);

    // R4: stray bytes before any start, then an over-long DVB packet
    repeat (3) put_byte(8'h11, 0, 0, 2);
    send_pkt(190, 0, 3, 8'h12, 2);
    // R5: mark set on byte 1, and a preset bit stays set
    send_pkt(188, 1, 9, 8'h1F, 2);
    send_pkt(188, 1, 5, 8'hA0, 2);
    drain_and_idle("after DVB parallel");

    // R6: DSS, uncorrectable, no marking, trimmed to 130
    cfg_dss = 1;
    send_pkt(132, 1, 7, 8'h05, 2);
    send_pkt(130, 0, 2, 8'h44, 2);
    drain_and_idle("after DSS parallel");

    // R10 and R9: inverted clock and error pin
    cfg_dss = 0; cfg_clk_inv = 1; cfg_err_inv = 1;
    @(negedge clk);
    chk(ts_err_o == 0, "R9", "idle inverted error pin", ts_err_o, 0);
    send_pkt(188, 1, 4, 8'h33, 2);
    send_pkt(188, 0, 6, 8'h21, 2);
    drain_and_idle("after inverted run");

    // R3: serial DVB then serial DSS
    cfg_clk_inv = 0; cfg_err_inv = 0; cfg_serial = 1;
    send_pkt(188, 1, 8, 8'h40, 16);
    drain_and_idle("after serial DVB");
    cfg_dss = 1;
    send_pkt(131, 1, 1, 8'h6C, 16);
    drain_and_idle("after serial DSS");

    // R8 / R9: no-signal mode
    cfg_err_nosig = 1;
    sig_lost = 1;
    repeat (2) @(negedge clk);
    chk(ts_err_o == 0, "R8", "no-signal asserted", ts_err_o, 0);
    sig_lost = 0;
    repeat (2) @(negedge clk);
    chk(ts_err_o == 1, "R8", "no-signal cleared", ts_err_o, 1);
    cfg_err_inv = 1;
    @(negedge clk);
    chk(ts_err_o == 0, "R9", "inverted no-signal idle", ts_err_o, 0);
    sig_lost = 1;
    repeat (2) @(negedge clk);
    chk(ts_err_o == 1, "R9", "inverted no-signal asserted", ts_err_o, 1);

    // R12
    cfg_oe = 0;
    #1;
    chk(ts_oe_o == 0, "R12", "oe low", ts_oe_o, 0);

    chk(sb.size() == 0, "R4", "scoreboard empty", sb.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule